// File: doc/BRIEF.md
# I2C Address and Direction Status Tracker

This block listens to an I2C bus whose SCL and SDA lines have already been brought into the system clock domain. It keeps three status flags about the transfer in progress: whether the first byte after a START carried this node's own 7-bit address, whether that byte began with a reserved extension pattern, and whether this node is currently the transmitter. It detects START and STOP, counts the clock pulses within each 9-clock frame and shifts in the first byte so that the flags can be settled on the 8th clock.

The direction flag follows different rules depending on the role. As a target, the received direction bit decides it. As a controller, a START on the bus sets it and a read direction bit clears it. Several events drop the flags: a STOP, an exit command, turning the block off, a lost arbitration, or a wait release during the acknowledge clock. An SDA output enable is raised only while this node is the transmitter, and only after the acknowledge clock of the address byte has ended.

Top module: `i2c_addr_status`

## Requirements
- R1: On the 8th SCL rising edge of the first frame after a START, `ext_code` is set when the four earliest received bits (frame bits 1 to 4) are all 0 or all 1. It becomes visible one clock after that edge.
- R2: On the same edge, `addr_hit` is set when frame bits 1 to 7 (MSB first) equal `own_addr[6:0]`. The flag rises only in the clock after an SCL rising edge.
- R3: `addr_hit` and `ext_code` are cleared by a START, a STOP, a one-clock `exit_cmd`, a 1-to-0 change of `en`, and reset.
- R4: With `is_ctrl` = 0, a START clears `tx_mode`. The 8th bit of the first frame (the direction bit) then sets `tx_mode` to its received value.
- R5: With `is_ctrl` = 1, a START sets `tx_mode`. A direction bit of 0 leaves it set, and a direction bit of 1 clears it.
- R6: `tx_mode` is cleared by a STOP, by `exit_cmd`, by a 1-to-0 change of `en`, by a rising edge of `arb_lost`, and by reset.
- R7: `wait_rel` high while the frame's 9th SCL clock is in progress (after its rising edge and before the next rising edge, START or STOP) clears `tx_mode` when `tx_mode` is set. This leaves `sda_oe` low.
- R8: `sda_oe` is 0 whenever `tx_mode` is 0. With `tx_mode` = 1 it goes high one clock after the falling SCL edge that ends the first frame's 9th clock, and never earlier in that frame.
- R9: START is SDA falling while SCL stays high, and STOP is SDA rising while SCL stays high. Each restarts the clock count, so a START in the middle of a frame begins a new first frame.
- R10: Frames after the first one following a START never change `addr_hit` or `ext_code`.
- R11: After reset all four outputs are 0, and while `en` is 0 no flag is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_in | input | 1 | Synchronised SCL level |
| sda_in | input | 1 | Synchronised SDA level |
| en | input | 1 | Block enable; a fall clears all flags |
| is_ctrl | input | 1 | 1 when this node acts as bus controller |
| own_addr | input | 7 | Programmed local address |
| exit_cmd | input | 1 | One-clock pulse: leave the current transfer |
| wait_rel | input | 1 | Wait release, active during the 9th clock |
| arb_lost | input | 1 | Arbitration lost indication (rising edge used) |
| addr_hit | output | 1 | Address match flag |
| ext_code | output | 1 | Extension code received flag |
| tx_mode | output | 1 | 1 = transmit status, 0 = receive status |
| sda_oe | output | 1 | SDA output enable |

## Verification
The assertions check on every cycle that STOP, the exit command, a fall of the enable and a rising arbitration-lost input clear the flags in the next clock. They also check that the address flag rises only right after an SCL rising edge, and that the SDA enable rises only right after an SCL falling edge. Whether a flag is set to the right value depends on the bits received, the role and the frame position, so only the bench's bus scenarios can show it. These scenarios cover matching and non-matching addresses, both extension patterns, later frames that must be ignored, repeated and mid-frame START, and a wait release in the acknowledge clock.

// File: rtl/i2c_trk_pkg.sv
// Shared definitions for the I2C address/direction status tracker.
// Assumes SCL and SDA are already synchronous to clk.
package i2c_trk_pkg;

    // Edge and condition pulses derived from the bus, one clk wide
    typedef struct packed {
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } bus_ev_t;

    // Width of the extension pattern check at the top of the address
    localparam int EXT_BITS_DEF = 4;

endpackage

// File: rtl/i2c_trk_events.sv
// Bus event detector: turns sampled SCL/SDA levels into edge, START and
// STOP pulses, plus edge pulses for the enable and arbitration inputs.
// Assumes inputs are glitch-free and synchronous; the idle bus is high.
module i2c_trk_events
    import i2c_trk_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    scl,
    input  logic    sda,
    input  logic    en,
    input  logic    arb_lost,
    output bus_ev_t ev,
    output logic    en_fall,
    output logic    arb_rise
);

    logic scl_q, sda_q, en_q, arb_q;

    // Keep last sampled level of each watched input
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
            en_q  <= 1'b0;
            arb_q <= 1'b0;
        end else begin
            scl_q <= scl;
            sda_q <= sda;
            en_q  <= en;
            arb_q <= arb_lost;
        end
    end

    // Derive one-clock event pulses from current and previous levels
    always_comb begin
        ev.scl_rise = scl & ~scl_q;
        ev.scl_fall = ~scl & scl_q;
        ev.start    = scl & scl_q & sda_q & ~sda;
        ev.stop     = scl & scl_q & ~sda_q & sda;
        en_fall     = en_q & ~en;
        arb_rise    = arb_lost & ~arb_q;
    end

endmodule

// File: rtl/i2c_trk_framer.sv
// Frame tracker: counts SCL clocks 1..9 within each frame, shifts in the
// first frame's address bits and flags the 8th clock (address/direction
// evaluation), the 9th clock window and the end of the first frame.
// Assumes START/STOP pulses never coincide with an SCL edge.
module i2c_trk_framer
    import i2c_trk_pkg::*;
#(
    parameter int ADDR_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  bus_ev_t           ev,
    input  logic              sda,
    output logic              addr_eval,
    output logic [ADDR_W-1:0] addr_bits,
    output logic              dir_bit,
    output logic              ack_slot,
    output logic              arm_pulse
);

    localparam int ACK_BIT = ADDR_W + 2;
    localparam int CNT_W   = $clog2(ACK_BIT + 1);
    localparam logic [CNT_W-1:0] ACK_CNT  = CNT_W'(ACK_BIT);
    localparam logic [CNT_W-1:0] ADDR_CNT = CNT_W'(ADDR_W);

    logic [CNT_W-1:0]  cnt_q;
    logic              first_q;
    logic [ADDR_W-1:0] shift_q;

    // Count clocks, shift bits and track whether this is the first frame
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            first_q <= 1'b0;
            shift_q <= '0;
        end else if (ev.start || ev.stop) begin
            cnt_q   <= '0;
            first_q <= ev.start;
        end else begin
            if (ev.scl_rise) begin
                cnt_q   <= (cnt_q == ACK_CNT) ? CNT_W'(1) : cnt_q + CNT_W'(1);
                shift_q <= {shift_q[ADDR_W-2:0], sda};
            end
            if (ev.scl_fall && cnt_q == ACK_CNT)
                first_q <= 1'b0;
        end
    end

    // Decode frame positions for the flag logic
    always_comb begin
        addr_eval = ev.scl_rise & first_q & (cnt_q == ADDR_CNT);
        addr_bits = shift_q;
        dir_bit   = sda;
        ack_slot  = (cnt_q == ACK_CNT);
        arm_pulse = ev.scl_fall & first_q & ack_slot;
    end

endmodule

// File: rtl/i2c_trk_flags.sv
// Status flag logic: address match, extension code, transmit status and
// the SDA output enable, applying the set and clear priorities.
// Assumes all event inputs are single-clock pulses from the framer/events.
module i2c_trk_flags #(
    parameter int ADDR_W = 7,
    parameter int EXT_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              is_ctrl,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              exit_cmd,
    input  logic              wait_rel,
    input  logic              en_fall,
    input  logic              arb_rise,
    input  logic              start,
    input  logic              stop,
    input  logic              addr_eval,
    input  logic [ADDR_W-1:0] addr_bits,
    input  logic              dir_bit,
    input  logic              ack_slot,
    input  logic              arm_pulse,
    output logic              addr_hit,
    output logic              ext_code,
    output logic              tx_mode,
    output logic              sda_oe
);

    logic hit_q, ext_q, tx_q, armed_q;
    logic ext_pat, addr_clr, tx_clr;

    // Extension pattern check on the top address bits, if configured
    generate
        if (EXT_W > 0) begin : g_ext
            always_comb ext_pat = (&addr_bits[ADDR_W-1 -: EXT_W]) |
                                  ~(|addr_bits[ADDR_W-1 -: EXT_W]);
        end else begin : g_no_ext
            always_comb ext_pat = 1'b0;
        end
    endgenerate

    // Collect clear conditions for each flag group
    always_comb begin
        addr_clr = start | stop | exit_cmd | en_fall;
        tx_clr   = stop | exit_cmd | en_fall | arb_rise |
                   (wait_rel & ack_slot & tx_q);
    end

    // Address-match and extension-code flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit_q <= 1'b0;
            ext_q <= 1'b0;
        end else if (addr_clr) begin
            hit_q <= 1'b0;
            ext_q <= 1'b0;
        end else if (en && addr_eval) begin
            hit_q <= hit_q | (addr_bits == own_addr);
            ext_q <= ext_q | ext_pat;
        end
    end

    // Transmit status by role
    always_ff @(posedge clk) begin
        if (!rst_n)
            tx_q <= 1'b0;
        else if (tx_clr)
            tx_q <= 1'b0;
        else if (start)
            tx_q <= en & is_ctrl;
        else if (en && addr_eval)
            tx_q <= is_ctrl ? (tx_q & ~dir_bit) : dir_bit;
    end

    // Arm the output enable once the first frame's 9th clock has ended
    always_ff @(posedge clk) begin
        if (!rst_n)
            armed_q <= 1'b0;
        else if (start || stop)
            armed_q <= 1'b0;
        else if (arm_pulse)
            armed_q <= 1'b1;
    end

    assign addr_hit = hit_q;
    assign ext_code = ext_q;
    assign tx_mode  = tx_q;
    assign sda_oe   = tx_q & armed_q;

endmodule

// File: rtl/i2c_addr_status.sv
// Top of the I2C address/direction status tracker. Connects the event
// detector, frame tracker and flag logic. Assumes scl_in/sda_in are
// synchronised to clk and each bus level lasts at least one clk.
module i2c_addr_status
    import i2c_trk_pkg::*;
#(
    parameter int ADDR_W = 7,
    parameter int EXT_W  = EXT_BITS_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_in,
    input  logic              sda_in,
    input  logic              en,
    input  logic              is_ctrl,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              exit_cmd,
    input  logic              wait_rel,
    input  logic              arb_lost,
    output logic              addr_hit,
    output logic              ext_code,
    output logic              tx_mode,
    output logic              sda_oe
);

    bus_ev_t           ev;
    logic              en_fall, arb_rise;
    logic              addr_eval, dir_bit, ack_slot, arm_pulse;
    logic [ADDR_W-1:0] addr_bits;

    i2c_trk_events u_ev (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl      (scl_in),
        .sda      (sda_in),
        .en       (en),
        .arb_lost (arb_lost),
        .ev       (ev),
        .en_fall  (en_fall),
        .arb_rise (arb_rise)
    );

    i2c_trk_framer #(.ADDR_W(ADDR_W)) u_frm (
        .clk       (clk),
        .rst_n     (rst_n),
        .ev        (ev),
        .sda       (sda_in),
        .addr_eval (addr_eval),
        .addr_bits (addr_bits),
        .dir_bit   (dir_bit),
        .ack_slot  (ack_slot),
        .arm_pulse (arm_pulse)
    );

    i2c_trk_flags #(.ADDR_W(ADDR_W), .EXT_W(EXT_W)) u_flg (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .is_ctrl   (is_ctrl),
        .own_addr  (own_addr),
        .exit_cmd  (exit_cmd),
        .wait_rel  (wait_rel),
        .en_fall   (en_fall),
        .arb_rise  (arb_rise),
        .start     (ev.start),
        .stop      (ev.stop),
        .addr_eval (addr_eval),
        .addr_bits (addr_bits),
        .dir_bit   (dir_bit),
        .ack_slot  (ack_slot),
        .arm_pulse (arm_pulse),
        .addr_hit  (addr_hit),
        .ext_code  (ext_code),
        .tx_mode   (tx_mode),
        .sda_oe    (sda_oe)
    );

endmodule

// File: rtl/i2c_addr_status_chk.sv
// Property checker for i2c_addr_status, attached by bind. Watches only
// the top-level ports.
module i2c_addr_status_chk (
    input logic clk,
    input logic rst_n,
    input logic scl_in,
    input logic sda_in,
    input logic en,
    input logic exit_cmd,
    input logic arb_lost,
    input logic addr_hit,
    input logic ext_code,
    input logic tx_mode,
    input logic sda_oe
);

    // R3
    stop_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_in && $past(scl_in) && !$past(sda_in) && sda_in)
        |=> (!addr_hit && !ext_code && !tx_mode));

    // R6
    exit_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exit_cmd |=> (!addr_hit && !ext_code && !tx_mode));

    // R3
    en_fall_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(en) |=> (!addr_hit && !ext_code && !tx_mode));

    // R6
    arb_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(arb_lost) |=> !tx_mode);

    // R2
    hit_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(addr_hit) |-> ($past(scl_in, 1) && !$past(scl_in, 2)));

    // R8
    oe_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> (!$past(scl_in, 1) && $past(scl_in, 2)));

endmodule

bind i2c_addr_status i2c_addr_status_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_in   (scl_in),
    .sda_in   (sda_in),
    .en       (en),
    .exit_cmd (exit_cmd),
    .arb_lost (arb_lost),
    .addr_hit (addr_hit),
    .ext_code (ext_code),
    .tx_mode  (tx_mode),
    .sda_oe   (sda_oe)
);

// File: tb/sim_i2c_addr_status.sv
// Bench for i2c_addr_status: drives bus waveforms, runs a behavioural
// reference model every clock and adds explicit per-scenario checks.
module sim_i2c_addr_status;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl = 1'b1, sda = 1'b1;
    logic       en = 1'b0, is_ctrl = 1'b0;
    logic [6:0] own = 7'h2A;
    logic       exit_cmd = 1'b0, wait_rel = 1'b0, arb = 1'b0;
    logic       addr_hit, ext_code, tx_mode, sda_oe;

    int total = 0;
    int bad = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    i2c_addr_status u0 (
        .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda),
        .en(en), .is_ctrl(is_ctrl), .own_addr(own),
        .exit_cmd(exit_cmd), .wait_rel(wait_rel), .arb_lost(arb),
        .addr_hit(addr_hit), .ext_code(ext_code),
        .tx_mode(tx_mode), .sda_oe(sda_oe)
    );

    // ---------------- behavioural reference model ----------------
    int  m_cnt;
    bit  m_first, m_armed, m_hit, m_ext, m_tx;
    bit  pscl, psda, pen, parb;
    bit  bits_q[$];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_first = 0; m_armed = 0;
            m_hit = 0; m_ext = 0; m_tx = 0;
            pscl = 1; psda = 1; pen = 0; parb = 0;
            bits_q.delete();
        end else begin
            bit rise, fall, st, sp, enf, arbr, eval;
            int addr;
            rise = scl && !pscl;
            fall = !scl && pscl;
            st   = scl && pscl && psda && !sda;
            sp   = scl && pscl && !psda && sda;
            enf  = pen && !en;
            arbr = arb && !parb;
            eval = rise && m_first && (m_cnt == 7);
            addr = 0;
            if (eval)
                for (int k = 0; k < 7; k++) addr = addr * 2 + int'(bits_q[k]);
            if (st || sp || exit_cmd || enf) begin
                m_hit = 0; m_ext = 0;
            end else if (en && eval) begin
                if (addr == int'(own)) m_hit = 1;
                if ((addr >> 3) == 0 || (addr >> 3) == 15) m_ext = 1;
            end
            if (sp || exit_cmd || enf || arbr || (wait_rel && m_cnt == 9 && m_tx))
                m_tx = 0;
            else if (st)
                m_tx = en && is_ctrl;
            else if (en && eval)
                m_tx = is_ctrl ? (sda ? 1'b0 : m_tx) : sda;
            if (st || sp) m_armed = 0;
            else if (fall && m_first && m_cnt == 9) m_armed = 1;
            if (st || sp) begin
                m_cnt = 0; m_first = st; bits_q.delete();
            end else begin
                if (rise) begin
                    m_cnt = (m_cnt == 9) ? 1 : m_cnt + 1;
                    bits_q.push_back(sda);
                end
                if (fall && m_cnt == 9) m_first = 0;
            end
            pscl = scl; psda = sda; pen = en; parb = arb;
        end
    end

    // Compare every clock, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            total += 4;
            if (ext_code !== m_ext) begin bad++; $display("FAIL R1 model ext_code got=%0b exp=%0b t=%0t", ext_code, m_ext, $time); end
            if (addr_hit !== m_hit) begin bad++; $display("FAIL R2 model addr_hit got=%0b exp=%0b t=%0t", addr_hit, m_hit, $time); end
            if (tx_mode !== m_tx) begin bad++; $display("FAIL R4 model tx_mode got=%0b exp=%0b t=%0t", tx_mode, m_tx, $time); end
            if (sda_oe !== (m_tx && m_armed)) begin bad++; $display("FAIL R8 model sda_oe got=%0b exp=%0b t=%0t", sda_oe, m_tx && m_armed, $time); end
        end
    end

    // ---------------- helpers ----------------
    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s got=%0b exp=%0b t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic flags(input string req, input logic h, input logic e,
                         input logic t, input logic o);
        chk({req, " addr_hit"}, addr_hit, h);
        chk({req, " ext_code"}, ext_code, e);
        chk({req, " tx_mode"},  tx_mode,  t);
        chk({req, " sda_oe"},   sda_oe,   o);
    endtask

    task automatic bus_start();
        scl = 1'b0; tick(1);
        sda = 1'b1; tick(1);
        scl = 1'b1; tick(1);
        sda = 1'b0; tick(2);
    endtask

    task automatic bus_stop();
        scl = 1'b0; tick(1);
        sda = 1'b0; tick(1);
        scl = 1'b1; tick(1);
        sda = 1'b1; tick(2);
    endtask

    // One clock pulse, left with SCL high
    task automatic clock_bit(input logic b);
        scl = 1'b0; sda = b; tick(2);
        scl = 1'b1; tick(2);
    endtask

    task automatic first8(input logic [7:0] v);
        for (int i = 7; i >= 0; i--) clock_bit(v[i]);
    endtask

    task automatic drop_scl();
        scl = 1'b0; tick(2);
    endtask

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // ---------------- scenarios ----------------
    initial begin
        tick(3);
        flags("R11 reset", 0, 0, 0, 0);
        rst_n = 1'b1; tick(2);
        flags("R11 after reset", 0, 0, 0, 0);

        // R11: disabled block sets nothing
        bus_start(); first8(8'h55);
        flags("R11 disabled", 0, 0, 0, 0);
        clock_bit(1'b0); bus_stop();
        en = 1'b1; tick(2);

        // Target write to own address, later frame ignored (R2, R4, R10)
        bus_start(); first8(8'h54);
        flags("R2 R4 own write 8th", 1, 0, 0, 0);
        clock_bit(1'b0); drop_scl();
        flags("R8 write after 9th", 1, 0, 0, 0);
        first8(8'h00);
        flags("R10 second frame", 1, 0, 0, 0);
        clock_bit(1'b0);
        bus_stop();
        flags("R3 stop", 0, 0, 0, 0);

        // Non-matching address
        bus_start(); first8(8'h56);
        flags("R2 mismatch", 0, 0, 0, 0);
        clock_bit(1'b0); bus_stop();

        // Target read: output enable only after the 9th clock ends (R4, R8)
        bus_start(); first8(8'h55);
        flags("R4 own read 8th", 1, 0, 1, 0);
        clock_bit(1'b0);
        flags("R8 during 9th", 1, 0, 1, 0);
        drop_scl();
        flags("R8 after 9th fall", 1, 0, 1, 1);
        first8(8'hA5); clock_bit(1'b1);
        bus_stop();
        flags("R6 stop clears tx", 0, 0, 0, 0);

        // Wait release in the 9th clock (R7)
        bus_start(); first8(8'h55); clock_bit(1'b0);
        wait_rel = 1'b1; tick(1); wait_rel = 1'b0; tick(1);
        flags("R7 wait release", 1, 0, 0, 0);
        drop_scl();
        flags("R7 no output enable", 1, 0, 0, 0);
        bus_stop();

        // Extension patterns and repeated START (R1, R3, R4)
        bus_start(); first8(8'h0E);
        flags("R1 low pattern", 0, 1, 0, 0);
        clock_bit(1'b0);
        bus_start();
        flags("R3 repeated start", 0, 0, 0, 0);
        first8(8'hF1);
        flags("R1 high pattern", 0, 1, 1, 0);
        clock_bit(1'b0);
        exit_cmd = 1'b1; tick(1); exit_cmd = 1'b0; tick(1);
        flags("R3 R6 exit", 0, 0, 0, 0);
        bus_stop();

        // Controller role (R5)
        is_ctrl = 1'b1;
        bus_start();
        flags("R5 start sets tx", 0, 0, 1, 0);
        first8(8'h20);
        flags("R5 dir 0 keeps tx", 0, 0, 1, 0);
        clock_bit(1'b0); drop_scl();
        flags("R5 R8 ctrl after 9th", 0, 0, 1, 1);
        bus_stop();
        bus_start(); first8(8'h21);
        flags("R5 dir 1 clears tx", 0, 0, 0, 0);
        clock_bit(1'b0); bus_stop();
        bus_start();
        arb = 1'b1; tick(2);
        flags("R6 arbitration lost", 0, 0, 0, 0);
        arb = 1'b0;
        bus_stop();
        is_ctrl = 1'b0;

        // Enable falling (R3, R6)
        bus_start(); first8(8'h55);
        flags("R3 pre enable drop", 1, 0, 1, 0);
        en = 1'b0; tick(2);
        flags("R3 R6 enable drop", 0, 0, 0, 0);
        en = 1'b1;
        clock_bit(1'b0); bus_stop();

        // START in the middle of a frame restarts the count (R9)
        bus_start(); clock_bit(1'b1); clock_bit(1'b1); clock_bit(1'b0);
        bus_start(); first8(8'h55);
        flags("R9 mid-frame restart", 1, 0, 1, 0);
        clock_bit(1'b0); bus_stop();
        flags("R9 stop", 0, 0, 0, 0);

        tick(4);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule